// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Acknowledge and Completion

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its best pending candidate: a line ID, the number of the CPU that raised it, and an 8-bit priority, where a smaller number means more urgent. The block compares that candidate with a programmable priority threshold and with the priority of the work the processor is already doing. When the candidate beats both, and signalling is enabled, it raises an interrupt request line to the processor.

Software talks to the block over a simple 32-bit register bus. Reading the acknowledge register claims the signalled interrupt. The read returns its identity and makes its priority the new running priority, which drops the request line until something more urgent arrives. Writing the same value to the completion register retires it and restores the running priority that applied before. A small stack of active entries lets more urgent interrupts preempt less urgent ones in strict nested order.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, the request line is low, the control register reads 0, the threshold register reads 0 and the running priority reads 0xFF.
- R2: Bit 0 of the control register (offset 0x00) enables signalling. While it is 0, the request line stays low for any candidate.
- R3: The threshold register (offset 0x04, bits [7:0]) lets a candidate be signalled only when the candidate's priority is numerically below the threshold.
- R4: The request line is a register. It is high in the cycle after a cycle in which the interface is enabled, a candidate is valid, and that candidate's priority is below both the threshold and the running priority.
- R5: A read of offset 0x0C while the candidate qualifies returns the line ID in bits [9:0] and the source CPU in bits [12:10], with 0 in the upper bits. The candidate's priority becomes the running priority.
- R6: A read of offset 0x0C while no candidate qualifies returns 1023 and leaves the running priority and the active entries unchanged.
- R7: A write to offset 0x10 whose full 32-bit value equals the value returned by the most recent still-active acknowledge completes that interrupt. The running priority returns to that of the next older active entry, or to 0xFF when none remain.
- R8: A write to offset 0x10 that does not match the newest active entry, or that arrives when nothing is active, has no effect.
- R9: Offset 0x14 reads the running priority. Offset 0x18 reads the pending candidate as {source CPU in bits [12:10], ID in bits [9:0]}, or 1023 when no candidate is valid, and this read changes no state.
- R10: When DEPTH interrupts are active, no further candidate is signalled and an acknowledge read returns 1023.
- R11: Read data appears on the data output one cycle after the read is presented. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate line ID |
| cand_src | input | 3 | Candidate source CPU number |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The gating is swept over every candidate priority against thresholds of 0x00, 0x80, 0xF0 and 0xFF. These sweeps separate an off-by-one threshold compare (less-than versus less-or-equal) from a correct one, and the 0x00 and 0xFF ends show whether the extremes mask everything. A nested acknowledge sequence with strictly falling priorities fills a four-deep stack, which tells apart correct push order, the full guard and the spurious reply. Completion writes are then issued with wrong, stale and correct values to show whether the pops restore each saved priority in reverse order.

// File: rtl/icif_pkg.sv
package icif_pkg;
  localparam int ID_W   = 10;
  localparam int SRC_W  = 3;
  localparam int PRIO_W = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_DONE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RUN   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PEEK  = 8'h18;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } act_entry_t;

  function automatic logic [DATA_W-1:0] pack_ident(logic [SRC_W-1:0] s, logic [ID_W-1:0] i);
    return {{(DATA_W-SRC_W-ID_W){1'b0}}, s, i};
  endfunction
endpackage

// File: rtl/icif_active_stack.sv
module icif_active_stack
  import icif_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  act_entry_t                    push_entry,
  input  logic                          pop,
  output act_entry_t                    top_entry,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          empty,
  output logic                          full
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  act_entry_t       mem [DEPTH];
  act_entry_t       top_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    wr_slot;
  logic [CW-1:0]    rd_slot;

  assign wr_slot = cnt_q - CW'(1);
  assign rd_slot = cnt_q - CW'(2);

  // storage below the top entry: single write port, one read port
  always_ff @(posedge clk) begin
    if (push && cnt_q != '0)
      mem[wr_slot[AW-1:0]] <= top_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      top_q <= '0;
    end else if (push) begin
      top_q <= push_entry;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop) begin
      if (cnt_q >= CW'(2))
        top_q <= mem[rd_slot[AW-1:0]];
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign top_entry = top_q;
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/icif_gate.sv
module icif_gate
  import icif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] threshold,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  output logic              qualify,
  output logic              irq_q
);
  assign qualify = enable && cand_valid && !stack_full &&
                   (cand_prio < threshold) && (cand_prio < run_prio);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= qualify;
  end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
  import icif_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cand_valid,
  input  logic [ID_W-1:0]    cand_id,
  input  logic [SRC_W-1:0]   cand_src,
  input  logic [PRIO_W-1:0]  cand_prio,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              qualify;
  logic              irq_q;
  logic              push;
  logic              pop;
  logic              ack_rd;
  logic              eoi_wr;
  logic              stk_empty;
  logic              stk_full;
  logic [CW-1:0]     act_count;
  act_entry_t        top_entry;
  act_entry_t        new_entry;
  logic [PRIO_W-1:0] run_prio;

  assign run_prio = stk_empty ? IDLE_PRIO : top_entry.prio;

  assign ack_rd = bus_sel && !bus_wr && (bus_addr == OFF_ACK);
  assign eoi_wr = bus_sel &&  bus_wr && (bus_addr == OFF_DONE);
  assign push   = ack_rd && qualify;
  assign pop    = eoi_wr && !stk_empty &&
                  (bus_wdata == pack_ident(top_entry.src, top_entry.id));

  assign new_entry.src  = cand_src;
  assign new_entry.id   = cand_id;
  assign new_entry.prio = cand_prio;

  icif_gate gate_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (ctrl_en),
    .cand_valid (cand_valid),
    .cand_prio  (cand_prio),
    .threshold  (pmr_q),
    .run_prio   (run_prio),
    .stack_full (stk_full),
    .qualify    (qualify),
    .irq_q      (irq_q)
  );

  icif_active_stack #(.DEPTH(DEPTH)) stack_i (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_entry (new_entry),
    .pop        (pop),
    .top_entry  (top_entry),
    .count      (act_count),
    .empty      (stk_empty),
    .full       (stk_full)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      pmr_q   <= '0;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == OFF_CTRL) ctrl_en <= bus_wdata[0];
      if (bus_addr == OFF_MASK) pmr_q   <= bus_wdata[PRIO_W-1:0];
    end
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CTRL: rdata_q <= {{(DATA_W-1){1'b0}}, ctrl_en};
        OFF_MASK: rdata_q <= {{(DATA_W-PRIO_W){1'b0}}, pmr_q};
        OFF_ACK:  rdata_q <= qualify ? pack_ident(cand_src, cand_id)
                                     : pack_ident('0, SPURIOUS_ID);
        OFF_RUN:  rdata_q <= {{(DATA_W-PRIO_W){1'b0}}, run_prio};
        OFF_PEEK: rdata_q <= cand_valid ? pack_ident(cand_src, cand_id)
                                        : pack_ident('0, SPURIOUS_ID);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/icif_checker.sv
module icif_checker
  import icif_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       irq_o,
  input logic                       ctrl_en,
  input logic [PRIO_W-1:0]          pmr_q,
  input logic [PRIO_W-1:0]          run_prio,
  input logic                       cand_valid,
  input logic [PRIO_W-1:0]          cand_prio,
  input logic                       ack_rd,
  input logic                       qualify,
  input logic                       eoi_wr,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] act_count,
  input logic [DATA_W-1:0]          bus_rdata
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq_o); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cand_prio >= pmr_q) |=> !irq_o); // R3

  AST_RUNNING_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cand_prio >= run_prio) |=> !irq_o); // R4

  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && qualify) |=> (run_prio == $past(cand_prio))); // R5

  AST_SPURIOUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !qualify) |=> (bus_rdata == 32'd1023) && $stable(act_count) && $stable(run_prio)); // R6

  AST_BAD_EOI_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && !pop && !ack_rd) |=> $stable(act_count) && $stable(run_prio)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    act_count <= ($clog2(DEPTH+1))'(DEPTH)); // R10

  AST_FULL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (act_count == ($clog2(DEPTH+1))'(DEPTH)) |=> !irq_o); // R10

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
    (act_count == '0) |-> (run_prio == IDLE_PRIO)); // R7

  AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |=> !irq_o); // R4
endmodule

bind irq_cpu_iface icif_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_o      (irq_o),
  .ctrl_en    (ctrl_en),
  .pmr_q      (pmr_q),
  .run_prio   (run_prio),
  .cand_valid (cand_valid),
  .cand_prio  (cand_prio),
  .ack_rd     (ack_rd),
  .qualify    (qualify),
  .eoi_wr     (eoi_wr),
  .pop        (pop),
  .act_count  (act_count),
  .bus_rdata  (bus_rdata)
);

// File: tb/irq_cpu_iface_tb.sv
module irq_cpu_iface_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [2:0]  cand_src = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_cpu_iface #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_src(cand_src), .cand_prio(cand_prio),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [2:0] s, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_src = s; cand_prio = p;
  endtask

  function automatic logic [31:0] ident(input logic [2:0] s, input logic [9:0] id);
    return {19'd0, s, id};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0]  masks [4];
    masks[0] = 8'h00; masks[1] = 8'h80; masks[2] = 8'hF0; masks[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(8'h00, d); check("R1 ctrl", d, 32'd0);
    rd(8'h04, d); check("R1 mask", d, 32'd0);
    rd(8'h14, d); check("R1 running", d, 32'hFF);
    // R9 peek with no candidate, R11 unmapped read
    rd(8'h18, d); check("R9 peek idle", d, 32'd1023);
    rd(8'h20, d); check("R11 unmapped", d, 32'd0);
    rd(8'h0C, d); check("R6 ack idle", d, 32'd1023);

    // R2 disabled: no request for any urgent candidate
    wr(8'h04, 32'hFF);
    for (int p = 0; p < 256; p += 17) begin
      cand(1'b1, 10'd5, 3'd1, 8'(p));
      settle();
      check("R2 disabled", {31'd0, irq_o}, 32'd0);
    end
    wr(8'h00, 32'd1);
    rd(8'h00, d); check("R2 ctrl readback", d, 32'd1);

    // R3/R4 threshold sweep: exhaustive over priority per threshold
    for (int m = 0; m < 4; m++) begin
      wr(8'h04, {24'd0, masks[m]});
      rd(8'h04, d); check("R3 mask readback", d, {24'd0, masks[m]});
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        cand_prio = 8'(p);
        @(negedge clk);
        check("R3 threshold gate", {31'd0, irq_o}, {31'd0, (8'(p) < masks[m])});
      end
    end
    // R4 invalid candidate never signals
    cand(1'b0, 10'd5, 3'd1, 8'h00);
    settle();
    check("R4 invalid cand", {31'd0, irq_o}, 32'd0);

    // R5 acknowledge
    wr(8'h04, 32'hF0);
    cand(1'b1, 10'd37, 3'd2, 8'h40);
    settle();
    check("R4 irq raised", {31'd0, irq_o}, 32'd1);
    rd(8'h0C, d); check("R5 ack value", d, ident(3'd2, 10'd37));
    settle();
    check("R4 irq after ack", {31'd0, irq_o}, 32'd0);
    rd(8'h14, d); check("R5 running", d, 32'h40);
    rd(8'h18, d); check("R9 peek nondestructive", d, ident(3'd2, 10'd37));
    rd(8'h14, d); check("R9 running after peek", d, 32'h40);

    // R4 preemption needs strictly more urgent
    cand(1'b1, 10'd50, 3'd0, 8'h40);
    settle();
    check("R4 equal no preempt", {31'd0, irq_o}, 32'd0);
    rd(8'h0C, d); check("R6 ack equal prio", d, 32'd1023);
    rd(8'h14, d); check("R6 running kept", d, 32'h40);
    cand(1'b1, 10'd50, 3'd0, 8'h20);
    settle();
    check("R4 preempt irq", {31'd0, irq_o}, 32'd1);
    rd(8'h0C, d); check("R5 nested ack", d, ident(3'd0, 10'd50));
    rd(8'h14, d); check("R5 nested running", d, 32'h20);

    // R8 wrong completions
    cand(1'b0, 10'd0, 3'd0, 8'hFF);
    wr(8'h10, ident(3'd2, 10'd37));
    rd(8'h14, d); check("R8 older id ignored", d, 32'h20);
    wr(8'h10, ident(3'd1, 10'd50));
    rd(8'h14, d); check("R8 wrong src ignored", d, 32'h20);
    wr(8'h10, 32'h0008_0032);
    rd(8'h14, d); check("R8 upper bits ignored", d, 32'h20);

    // R7 completions in reverse order
    wr(8'h10, ident(3'd0, 10'd50));
    rd(8'h14, d); check("R7 pop to previous", d, 32'h40);
    wr(8'h10, ident(3'd2, 10'd37));
    rd(8'h14, d); check("R7 pop to idle", d, 32'hFF);
    wr(8'h10, ident(3'd2, 10'd37));
    rd(8'h14, d); check("R8 eoi when idle", d, 32'hFF);

    // R6 masked candidate gives spurious
    wr(8'h04, 32'h10);
    cand(1'b1, 10'd9, 3'd3, 8'h30);
    rd(8'h0C, d); check("R6 masked spurious", d, 32'd1023);
    rd(8'h14, d); check("R6 running unchanged", d, 32'hFF);

    // R10 fill the stack with strictly falling priorities
    wr(8'h04, 32'hFF);
    for (int k = 0; k < DEPTH; k++) begin
      cand(1'b1, 10'(100 + k), 3'd0, 8'(8'h50 - 8'(k * 16)));
      rd(8'h0C, d); check("R5 fill ack", d, ident(3'd0, 10'(100 + k)));
    end
    rd(8'h14, d); check("R10 running at full", d, 32'h20);
    cand(1'b1, 10'd200, 3'd0, 8'h05);
    settle();
    check("R10 full no irq", {31'd0, irq_o}, 32'd0);
    rd(8'h0C, d); check("R10 full spurious", d, 32'd1023);
    cand(1'b0, 10'd0, 3'd0, 8'hFF);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      wr(8'h10, ident(3'd0, 10'(100 + k)));
      rd(8'h14, d);
      check("R7 unwind", d, (k == 0) ? 32'hFF : {24'd0, 8'(8'h50 - 8'((k - 1) * 16))});
    end

    // R2 disabling drops request
    cand(1'b1, 10'd7, 3'd0, 8'h01);
    settle();
    check("R2 enabled irq", {31'd0, irq_o}, 32'd1);
    wr(8'h00, 32'd0);
    settle();
    check("R2 disable drops irq", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule